// File: doc/BRIEF.md
# Flash Page Allocator with Wear-Aware Reclaim

This block keeps the bookkeeping for a small NAND-style array: a per-page state (erased, holding live data, or stale) and a per-block erase counter. Data is never rewritten in place. Each logical write takes the next erased page of the currently open block and programs it. When the request also names the page that held the previous copy, that page is marked stale when the request is accepted. When the open block is full, a fresh block is opened. The fresh block is the erased block with the fewest erases.

One erased block is always held back as a reserve. If the open block is full and only the reserve is left, the block reclaims space before it serves the write. It chooses the non-erased block with the most stale pages as the victim. It copies that block's live pages into the reserve, erases the victim and returns it to the erased pool. The former reserve then becomes the open block, and the write continues there. Every page operation is issued to the flash on a command stream with valid/ready handshaking.

The requester keeps at most (blocks − 1) × pages − 1 live pages. The requester watches COPY commands to follow relocated data. Requests use valid/ready: a request is taken on a cycle where both are high, and `req_ready` is low for as long as `busy` is high. Commands are offered with `cmd_valid` and complete on `cmd_ready`. While a command waits, the block holds it unchanged, and the receiver may stall it for any number of cycles.

Top module: `flash_reclaim_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1 and `cmd_valid` is 0; all pages are erased, all blocks are in the erased pool and all erase counts are zero.
- R2: When a write needs a new block and more than one erased block exists, the block opened is the erased block with the lowest erase count, with ties going to the lowest index; non-erased blocks are never considered.
- R3: A write programs the next unused page of the open block, pages being taken in ascending order from 0. A PROGRAM command has `cmd_op`=0, carries the target in `cmd_dst_blk`/`cmd_dst_page`, and has zero source fields. A page only moves back to the erased state through an erase of its block.
- R4: A request with `req_tgt_vld`=1 marks the page (`req_blk`,`req_page`) stale if it holds live data, as the request is accepted. If the page is erased or already stale, the request has no effect. A request with `req_write`=0 performs only this step.
- R5: Reclaim starts only when a write finds the open block full and exactly one erased block left, and outside a reclaim at least one erased block always exists.
- R6: The reclaim victim is the non-erased block with the most stale pages, with ties going to the lowest index. It is erased with one ERASE command: `cmd_op`=2, block in `cmd_dst_blk`, all other fields zero.
- R7: Before the erase, every live page of the victim is copied in ascending page order into the reserve block, filling it from page 0. A COPY command has `cmd_op`=1, source in `cmd_src_*` and destination in `cmd_dst_*`. The reserve then becomes the open block, and the pending write programs its next page.
- R8: Each erase adds one to the victim's erase count, and the count holds at its maximum value instead of wrapping.
- R9: `busy` rises on the cycle after a write is accepted and stays high until its PROGRAM completes. `req_ready` is low while `busy` is high. No command is offered while `busy` is low.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and every command field stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1: allocate and program a page; 0: invalidate only |
| req_tgt_vld | input | 1 | Page named by req_blk/req_page is to be marked stale |
| req_blk | input | $clog2(NBLK) | Block of the page to mark stale |
| req_page | input | $clog2(NPG) | Page of the page to mark stale |
| busy | output | 1 | A write or reclaim is in progress |
| cmd_valid | output | 1 | Flash command offered |
| cmd_ready | input | 1 | Flash accepts the command |
| cmd_op | output | 2 | 0 program, 1 copy, 2 erase |
| cmd_dst_blk | output | $clog2(NBLK) | Target block |
| cmd_dst_page | output | $clog2(NPG) | Target page |
| cmd_src_blk | output | $clog2(NBLK) | Copy source block |
| cmd_src_page | output | $clog2(NPG) | Copy source page |

## Verification
Several properties are checked on every cycle: command stability under stall, the absence of commands while idle, and that PROGRAM and COPY only target erased pages and COPY only reads live ones. The checks also cover the rule that page bits return to the erased state only on an erase, the non-decreasing erase counters and the ever-present erased block. The choice of blocks cannot be seen by a single-cycle property. This covers lowest-wear opening, most-stale victim selection and counter saturation changing those choices. It also covers ignored invalidations and requests refused while busy. Only the bench's long mixed write/invalidate sequences show these, compared command by command against a model of the rules.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  // Page state codes: erased is all ones, programming only clears bits.
  localparam logic [1:0] PG_FREE    = 2'b11;
  localparam logic [1:0] PG_VALID   = 2'b10;
  localparam logic [1:0] PG_INVALID = 2'b00;

  localparam logic [1:0] FC_PROGRAM = 2'd0;
  localparam logic [1:0] FC_COPY    = 2'd1;
  localparam logic [1:0] FC_ERASE   = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ALLOC, S_MOVE, S_ERASE} fsm_e;
endpackage

// File: rtl/fbr_pick.sv
// Selects the eligible entry with the smallest (or largest) value; the
// lowest index wins a tie because only a strictly better value replaces.
module fbr_pick #(
  parameter int N        = 8,
  parameter int W        = 4,
  parameter bit PICK_MAX = 1'b0,
  localparam int IW      = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] vals,
  input  logic [N-1:0]        elig,
  output logic [IW-1:0]       idx,
  output logic                found
);
  logic [W-1:0] best;
  logic [N-1:0] better;

  generate
    for (genvar i = 0; i < N; i++) begin : g_cmp
      if (PICK_MAX) begin : g_max
        assign better[i] = vals[i] > best;
      end else begin : g_min
        assign better[i] = vals[i] < best;
      end
    end
  endgenerate

  // best is only read for entries after the current one; evaluate serially.
  always_comb begin
    logic [W-1:0] run;
    idx   = '0;
    found = 1'b0;
    run   = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || (PICK_MAX ? (vals[i] > run) : (vals[i] < run)))) begin
        found = 1'b1;
        run   = vals[i];
        idx   = IW'(i);
      end
    end
    best = run;
  end

  logic unused_better;
  assign unused_better = ^better;
endmodule

// File: rtl/fbr_blk_tally.sv
// Counts the stale pages of one block.
module fbr_blk_tally #(
  parameter int NPG = 4,
  localparam int CW = $clog2(NPG + 1)
) (
  input  logic [NPG-1:0][1:0] pages,
  output logic [CW-1:0]       inv_cnt
);
  import fbr_pkg::*;
  always_comb begin
    inv_cnt = '0;
    for (int p = 0; p < NPG; p++) begin
      if (pages[p] == PG_INVALID) inv_cnt = inv_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/flash_reclaim_ctrl.sv
module flash_reclaim_ctrl #(
  parameter int NBLK = 8,
  parameter int NPG  = 4,
  parameter int ECW  = 4,
  localparam int BW  = $clog2(NBLK),
  localparam int PW  = $clog2(NPG),
  localparam int CW  = $clog2(NPG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_tgt_vld,
  input  logic [BW-1:0] req_blk,
  input  logic [PW-1:0] req_page,
  output logic          busy,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [BW-1:0] cmd_dst_blk,
  output logic [PW-1:0] cmd_dst_page,
  output logic [BW-1:0] cmd_src_blk,
  output logic [PW-1:0] cmd_src_page
);
  import fbr_pkg::*;

  fsm_e                         state;
  logic [NBLK-1:0][NPG-1:0][1:0] pg_st;
  logic [NBLK-1:0][ECW-1:0]      ecnt;
  logic [NBLK-1:0]               blk_free;
  logic                          act_vld;
  logic [BW-1:0]                 act_blk;
  logic [CW-1:0]                 act_wp;
  logic [BW-1:0]                 vic_q;
  logic [BW-1:0]                 dst_q;
  logic [CW-1:0]                 scan_q;
  logic [CW-1:0]                 dwp_q;

  logic [NBLK-1:0][CW-1:0]       inv_cnt;
  logic [BW-1:0]                 free_idx, vic_idx;
  logic                          free_any, vic_any;
  logic [BW:0]                   free_cnt;
  logic                          room;
  logic                          scan_done;
  logic                          scan_live;

  generate
    for (genvar b = 0; b < NBLK; b++) begin : g_tally
      fbr_blk_tally #(.NPG(NPG)) u_tally (
        .pages   (pg_st[b]),
        .inv_cnt (inv_cnt[b])
      );
    end
  endgenerate

  fbr_pick #(.N(NBLK), .W(ECW), .PICK_MAX(1'b0)) u_pick_free (
    .vals  (ecnt),
    .elig  (blk_free),
    .idx   (free_idx),
    .found (free_any)
  );

  fbr_pick #(.N(NBLK), .W(CW), .PICK_MAX(1'b1)) u_pick_victim (
    .vals  (inv_cnt),
    .elig  (~blk_free),
    .idx   (vic_idx),
    .found (vic_any)
  );

  assign free_cnt  = (BW + 1)'($countones(blk_free));
  assign room      = act_vld && (act_wp < CW'(NPG));
  assign scan_done = (scan_q == CW'(NPG));
  assign scan_live = !scan_done && (pg_st[vic_q][scan_q[PW-1:0]] == PG_VALID);
  assign busy      = (state != S_IDLE);
  assign req_ready = (state == S_IDLE);

  always_comb begin
    cmd_valid    = 1'b0;
    cmd_op       = FC_PROGRAM;
    cmd_dst_blk  = '0;
    cmd_dst_page = '0;
    cmd_src_blk  = '0;
    cmd_src_page = '0;
    case (state)
      S_ALLOC: begin
        if (room) begin
          cmd_valid    = 1'b1;
          cmd_dst_blk  = act_blk;
          cmd_dst_page = act_wp[PW-1:0];
        end
      end
      S_MOVE: begin
        if (scan_live) begin
          cmd_valid    = 1'b1;
          cmd_op       = FC_COPY;
          cmd_dst_blk  = dst_q;
          cmd_dst_page = dwp_q[PW-1:0];
          cmd_src_blk  = vic_q;
          cmd_src_page = scan_q[PW-1:0];
        end
      end
      S_ERASE: begin
        cmd_valid   = 1'b1;
        cmd_op      = FC_ERASE;
        cmd_dst_blk = vic_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pg_st    <= '1;
      ecnt     <= '0;
      blk_free <= '1;
      act_vld  <= 1'b0;
      act_blk  <= '0;
      act_wp   <= '0;
      vic_q    <= '0;
      dst_q    <= '0;
      scan_q   <= '0;
      dwp_q    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (req_tgt_vld && pg_st[req_blk][req_page] == PG_VALID)
              pg_st[req_blk][req_page] <= PG_INVALID;
            if (req_write) state <= S_ALLOC;
          end
        end
        S_ALLOC: begin
          if (room) begin
            if (cmd_ready) begin
              pg_st[act_blk][act_wp[PW-1:0]] <= PG_VALID;
              act_wp <= act_wp + CW'(1);
              state  <= S_IDLE;
            end
          end else if (free_cnt > (BW + 1)'(1)) begin
            act_blk            <= free_idx;
            act_vld            <= 1'b1;
            act_wp             <= '0;
            blk_free[free_idx] <= 1'b0;
          end else if (free_any && vic_any) begin
            vic_q              <= vic_idx;
            dst_q              <= free_idx;
            blk_free[free_idx] <= 1'b0;
            act_vld            <= 1'b0;
            scan_q             <= '0;
            dwp_q              <= '0;
            state              <= S_MOVE;
          end
        end
        S_MOVE: begin
          if (scan_done) begin
            state <= S_ERASE;
          end else if (scan_live) begin
            if (cmd_ready) begin
              pg_st[dst_q][dwp_q[PW-1:0]]  <= PG_VALID;
              pg_st[vic_q][scan_q[PW-1:0]] <= PG_INVALID;
              dwp_q  <= dwp_q + CW'(1);
              scan_q <= scan_q + CW'(1);
            end
          end else begin
            scan_q <= scan_q + CW'(1);
          end
        end
        S_ERASE: begin
          if (cmd_ready) begin
            pg_st[vic_q] <= '1;
            if (ecnt[vic_q] != {ECW{1'b1}}) ecnt[vic_q] <= ecnt[vic_q] + ECW'(1);
            blk_free[vic_q] <= 1'b1;
            act_blk <= dst_q;
            act_vld <= 1'b1;
            act_wp  <= dwp_q;
            state   <= S_ALLOC;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbr_chk.sv
module fbr_chk #(
  parameter int NBLK = 8,
  parameter int NPG  = 4,
  parameter int ECW  = 4,
  localparam int BW  = $clog2(NBLK),
  localparam int PW  = $clog2(NPG)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          req_write,
  input logic                          busy,
  input logic                          cmd_valid,
  input logic                          cmd_ready,
  input logic [1:0]                    cmd_op,
  input logic [BW-1:0]                 cmd_dst_blk,
  input logic [PW-1:0]                 cmd_dst_page,
  input logic [BW-1:0]                 cmd_src_blk,
  input logic [PW-1:0]                 cmd_src_page,
  input logic [NBLK-1:0][NPG-1:0][1:0] pg_st,
  input logic [NBLK-1:0][ECW-1:0]      ecnt,
  input logic [NBLK-1:0]               blk_free
);
  p_write_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> busy);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_dst_blk)
      && $stable(cmd_dst_page) && $stable(cmd_src_blk) && $stable(cmd_src_page));

  p_prog_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd0 |-> pg_st[cmd_dst_blk][cmd_dst_page] == 2'b11);

  p_copy_pages_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 |-> pg_st[cmd_src_blk][cmd_src_page] == 2'b10
      && pg_st[cmd_dst_blk][cmd_dst_page] == 2'b11);

  p_reserve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $countones(blk_free) >= 1);

  generate
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
      p_count_nowrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ecnt[b] >= $past(ecnt[b]));
      for (genvar p = 0; p < NPG; p++) begin : g_pg
        p_only_erase_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
          !(cmd_valid && cmd_ready && cmd_op == 2'd2 && cmd_dst_blk == BW'(b))
          |=> (pg_st[b][p] & ~$past(pg_st[b][p])) == 2'b00);
      end
    end
  endgenerate
endmodule

bind flash_reclaim_ctrl fbr_chk #(.NBLK(NBLK), .NPG(NPG), .ECW(ECW)) u_fbr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .busy         (busy),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .cmd_dst_blk  (cmd_dst_blk),
  .cmd_dst_page (cmd_dst_page),
  .cmd_src_blk  (cmd_src_blk),
  .cmd_src_page (cmd_src_page),
  .pg_st        (pg_st),
  .ecnt         (ecnt),
  .blk_free     (blk_free)
);

// File: tb/test_flash_reclaim_ctrl.sv
module test_flash_reclaim_ctrl;
  localparam int NB = 8;
  localparam int NP = 4;
  localparam int ECMAX = 3;   // bench uses a 2-bit erase counter
  localparam int NL = 20;     // logical pages kept live

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_tgt_vld = 1'b0;
  logic [2:0] req_blk = '0;
  logic [1:0] req_page = '0;
  logic cmd_ready = 1'b0;
  logic req_ready, busy, cmd_valid;
  logic [1:0] cmd_op;
  logic [2:0] cmd_dst_blk, cmd_src_blk;
  logic [1:0] cmd_dst_page, cmd_src_page;

  always #2 clk = ~clk;

  flash_reclaim_ctrl #(.NBLK(NB), .NPG(NP), .ECW(2)) i_flash_reclaim_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_tgt_vld(req_tgt_vld), .req_blk(req_blk),
    .req_page(req_page), .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst_blk(cmd_dst_blk), .cmd_dst_page(cmd_dst_page),
    .cmd_src_blk(cmd_src_blk), .cmd_src_page(cmd_src_page));

  int checks = 0, fails = 0;
  // model: 0 erased, 1 live, 2 stale
  int pst[NB][NP];
  int rev[NB][NP];
  int bfree[NB], ec[NB], raw_ec[NB];
  int act = 0, actv = 0, wp = 0;
  int l2b[NL], l2p[NL], l2v[NL];
  int ekey[16];
  string etag[16];
  int en = 0;
  string force_tag = "";
  int stall_ctr = 0;
  logic busy_test = 1'b0;
  int bt_blk = 0, bt_pg = 0;

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int mkkey(int op, int db, int dp, int sb, int sp);
    return op * 65536 + db * 4096 + dp * 256 + sb * 16 + sp;
  endfunction

  function automatic int dut_key();
    return mkkey(int'(cmd_op), int'(cmd_dst_blk), int'(cmd_dst_page),
                 int'(cmd_src_blk), int'(cmd_src_page));
  endfunction

  function automatic int pick_free();
    int best = -1;
    for (int b = 0; b < NB; b++)
      if (bfree[b] != 0 && (best < 0 || ec[b] < ec[best])) best = b;
    return best;
  endfunction

  function automatic int pick_victim();
    int best = -1, bc = -1;
    for (int b = 0; b < NB; b++) begin
      if (bfree[b] == 0) begin
        int c = 0;
        for (int p = 0; p < NP; p++) if (pst[b][p] == 2) c++;
        if (best < 0 || c > bc) begin best = b; bc = c; end
      end
    end
    return best;
  endfunction

  function automatic int any_sat();
    for (int b = 0; b < NB; b++) if (raw_ec[b] > ECMAX) return 1;
    return 0;
  endfunction

  task automatic push(input int k, input string t);
    ekey[en] = k; etag[en] = t; en++;
  endtask

  task automatic m_inval(input int b, input int p);
    if (pst[b][p] == 1) begin
      pst[b][p] = 2;
      if (rev[b][p] >= 0) l2v[rev[b][p]] = 0;
      rev[b][p] = -1;
    end
  endtask

  task automatic m_write(input int lpn);
    string tag = "R3";
    en = 0;
    forever begin
      if (actv != 0 && wp < NP) begin
        if (force_tag != "") begin tag = force_tag; force_tag = ""; end
        push(mkkey(0, act, wp, 0, 0), tag);
        pst[act][wp] = 1; rev[act][wp] = lpn;
        l2b[lpn] = act; l2p[lpn] = wp; l2v[lpn] = 1;
        wp++;
        break;
      end else begin
        int nf = 0;
        for (int b = 0; b < NB; b++) nf += bfree[b];
        if (nf > 1) begin
          act = pick_free(); actv = 1; wp = 0; bfree[act] = 0;
          tag = (any_sat() != 0) ? "R8" : "R2";
          force_tag = "";
        end else begin
          int v = pick_victim();
          int d = pick_free();
          int dw = 0;
          bit first = 1'b1;
          bfree[d] = 0; actv = 0;
          for (int p = 0; p < NP; p++) begin
            if (pst[v][p] == 1) begin
              push(mkkey(1, d, dw, v, p), first ? "R5" : "R7");
              first = 1'b0;
              pst[d][dw] = 1; rev[d][dw] = rev[v][p];
              if (rev[v][p] >= 0) begin l2b[rev[v][p]] = d; l2p[rev[v][p]] = dw; end
              pst[v][p] = 2; rev[v][p] = -1;
              dw++;
            end
          end
          push(mkkey(2, v, 0, 0, 0), first ? "R5" : "R6");
          for (int p = 0; p < NP; p++) begin pst[v][p] = 0; rev[v][p] = -1; end
          raw_ec[v]++;
          if (ec[v] < ECMAX) ec[v]++;
          bfree[v] = 1; act = d; actv = 1; wp = dw;
          tag = "R7";
          force_tag = "";
        end
      end
    end
  endtask

  task automatic send_req(input bit wr, input bit tv, input int b, input int p);
    int w = 0;
    @(negedge clk);
    while (!req_ready && w < 50) begin @(negedge clk); w++; end
    req_write = wr; req_tgt_vld = tv; req_blk = 3'(b); req_page = 2'(p);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) chk(busy && !req_ready, "R9 busy after write", int'(busy), 1);
    else    chk(!busy && req_ready, "R4 invalidate leaves idle", int'(busy), 0);
  endtask

  task automatic serve();
    for (int k = 0; k < en; k++) begin
      int w = 0;
      int stall;
      int k0;
      while (!cmd_valid && w < 40) begin @(negedge clk); w++; end
      if (!cmd_valid) begin
        chk(1'b0, "R9 command missing", 0, ekey[k]);
        return;
      end
      stall = stall_ctr % 3; stall_ctr++;
      if (busy_test && k == 0) begin
        stall = 3;
        req_write = 1'b0; req_tgt_vld = 1'b1;
        req_blk = 3'(bt_blk); req_page = 2'(bt_pg); req_valid = 1'b1;
      end
      k0 = dut_key();
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(cmd_valid && dut_key() == k0, "R10 held command", dut_key(), k0);
        if (busy_test && k == 0) chk(!req_ready, "R9 refused while busy", int'(req_ready), 0);
      end
      req_valid = 1'b0;
      chk(dut_key() == ekey[k], etag[k], dut_key(), ekey[k]);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
    end
    chk(!busy && !cmd_valid, "R9 idle after write", int'(busy), 0);
  endtask

  task automatic do_write(input int lpn);
    bit tv = (l2v[lpn] != 0);
    int ob = l2b[lpn], op = l2p[lpn];
    if (tv) m_inval(ob, op);
    m_write(lpn);
    send_req(1'b1, tv, ob, op);
    serve();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int b = 0; b < NB; b++) begin
      bfree[b] = 1; ec[b] = 0; raw_ec[b] = 0;
      for (int p = 0; p < NP; p++) begin pst[b][p] = 0; rev[b][p] = -1; end
    end
    for (int l = 0; l < NL; l++) begin l2v[l] = 0; l2b[l] = 0; l2p[l] = 0; end

    repeat (3) @(negedge clk);
    chk(!busy && req_ready && !cmd_valid, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req_ready && !cmd_valid, "R1 after release", int'(cmd_valid), 0);

    for (int l = 0; l < NL; l++) do_write(l);

    for (int i = 0; i < 400; i++) begin
      int lpn;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lpn = int'(lf) % NL;
      if (i % 17 == 3 && l2v[lpn] != 0) begin
        int b = l2b[lpn], p = l2p[lpn];
        m_inval(b, p);
        send_req(1'b0, 1'b1, b, p);
        send_req(1'b0, 1'b1, b, p);   // already stale: no effect (R4)
      end else if (i % 23 == 5 && actv != 0 && wp < NP) begin
        send_req(1'b0, 1'b1, act, wp); // erased page: no effect (R4)
        force_tag = "R4";
        do_write(lpn);
      end else if (i % 29 == 7) begin
        int other = (lpn + 1) % NL;
        if (l2v[other] != 0) begin
          busy_test = 1'b1; bt_blk = l2b[other]; bt_pg = l2p[other];
        end
        do_write(lpn);
        busy_test = 1'b0;
      end else begin
        do_write(lpn);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule